// File: doc/BRIEF.md
# Serial-Loaded Switch Control Register

This block receives an 8-bit control word over a three-wire serial link and turns it into eight switch-enable lines. A frame starts when the active-low frame strobe falls. While the strobe is low, each falling edge of the serial clock moves one data bit into a shift register, most significant bit first. When the strobe rises, the whole word is copied into the enable register in a single step. The switches therefore never see a half-loaded word.

The most significant bit of the shift register is retimed on each rising clock edge and sent out on a chain output. A second unit can take its data from this output, so several units can share one clock and one strobe and be loaded as one long word. The same output also lets software read back what it shifted in. The output is open-drain: the pin is pulled low for a 0 and released for a 1. An active-low reset acts at once, without waiting for a clock edge. It opens every switch and clears all state.

Top module: `serial_switch_ctl`

## Requirements
- R1: While `rst_n` is low, `sw_en` is all zeros, the shift register is all zeros, `so_d` is 0 and `so_drive_low` is 1. Reset takes effect without waiting for a clock edge.
- R2: On each falling edge of `sclk` with `sync_n` low, the register moves up one place and `sdi` enters bit 0. The first bit sent therefore ends up at bit 7 after eight edges.
- R3: Falling edges of `sclk` while `sync_n` is high leave the shift register unchanged, whatever `sdi` carries.
- R4: On the rising edge of `sync_n`, the shift register is copied to `sw_en`. Bit n of the word drives `sw_en[n]`, which controls switch n+1, and a 1 closes the switch.
- R5: `sw_en` does not change while a frame is being shifted in.
- R6: On each rising edge of `sclk`, `so_d` takes bit 7 of the shift register. `so_drive_low` is 1 exactly when `so_d` is 0 (open-drain: drive low, or release).
- R7: A frame of any length latches the last eight bits shifted in. For a frame shorter than eight bits, those last eight bits include bits left over from earlier frames. No error is flagged.
- R8: When one unit's `sdi` is connected to another unit's `so_d` and a 16-bit frame is sent, the first eight bits land in the downstream unit and the last eight stay in the first unit.
- R9: A reset asserted in the middle of a frame discards the partial word. The next frame then loads normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock; data is taken on falling edges, the chain output moves on rising edges |
| sdi | input | 1 | Serial data in, most significant bit first |
| sync_n | input | 1 | Active-low frame strobe; its rising edge updates the switches |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_en | output | 8 | Switch enables; bit n drives switch n+1, 1 = closed |
| so_d | output | 1 | Chain/readback data (bit 7 of the shift register, retimed) |
| so_drive_low | output | 1 | Open-drain pull-down enable for the chain pin |

## Verification
Full 8-bit words are sent with alternating bits, all ones, all zeros and words with only the end bits set. These patterns expose a reversed bit order and a stuck enable line. Frames of 4 bits and 12 bits show whether the latched word is made of the most recent eight bits. A 16-bit frame through two chained units separates a correctly retimed chain output from one shifted by a half or a full clock. A readback frame follows the output bit by bit. Clock edges while the strobe is high, and a reset in the middle of a frame, are each followed by a frame strobe with no clock edges in it. This brings the state of the shift register out to the enables.

// File: rtl/ssc_pkg.sv
`timescale 1ns/1ps
package ssc_pkg;
  localparam int unsigned SW_COUNT = 8;
  localparam int unsigned MSB_IDX  = SW_COUNT - 1;

  typedef logic [SW_COUNT-1:0] ssc_word_t;

  // Next shift-register value: move up one place, new bit enters at bit 0.
  function automatic ssc_word_t shift_in(ssc_word_t cur, logic din);
    return {cur[MSB_IDX-1:0], din};
  endfunction

  // Bit presented on the chain output.
  function automatic logic chain_bit(ssc_word_t w);
    return w[MSB_IDX];
  endfunction

  // Word-to-switch mapping: bit n drives switch n+1, 1 = closed.
  function automatic ssc_word_t to_enables(ssc_word_t w);
    ssc_word_t en;
    for (int i = 0; i < SW_COUNT; i++) en[i] = w[i];
    return en;
  endfunction
endpackage

// File: rtl/ssc_shift_stage.sv
`timescale 1ns/1ps
module ssc_shift_stage
  import ssc_pkg::*;
(
  input  logic      sclk,
  input  logic      rst_n,
  input  logic      sync_n,
  input  logic      sdi,
  output ssc_word_t shreg_q,
  output logic      accept
);
  // Frame open: falling edges of sclk shift data in.
  assign accept = ~sync_n;

  always_ff @(negedge sclk or negedge rst_n) begin
    if (!rst_n)      shreg_q <= '0;
    else if (accept) shreg_q <= shift_in(shreg_q, sdi);
  end
endmodule

// File: rtl/ssc_chain_stage.sv
`timescale 1ns/1ps
module ssc_chain_stage
  import ssc_pkg::*;
(
  input  logic      sclk,
  input  logic      rst_n,
  input  ssc_word_t shreg,
  output logic      so_d,
  output logic      so_drive_low
);
  logic so_q;

  // Retimed on the rising edge so a downstream unit samples a stable bit.
  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) so_q <= 1'b0;
    else        so_q <= chain_bit(shreg);
  end

  assign so_d         = so_q;
  assign so_drive_low = ~so_q;
endmodule

// File: rtl/ssc_latch_stage.sv
`timescale 1ns/1ps
module ssc_latch_stage
  import ssc_pkg::*;
(
  input  logic      sync_n,
  input  logic      rst_n,
  input  ssc_word_t shreg,
  output ssc_word_t sw_q
);
  // The end of the frame is the update event for the switch state.
  always_ff @(posedge sync_n or negedge rst_n) begin
    if (!rst_n) sw_q <= '0;
    else        sw_q <= to_enables(shreg);
  end
endmodule

// File: rtl/serial_switch_ctl.sv
`timescale 1ns/1ps
module serial_switch_ctl
  import ssc_pkg::*;
(
  input  logic                sclk,
  input  logic                sdi,
  input  logic                sync_n,
  input  logic                rst_n,
  output logic [SW_COUNT-1:0] sw_en,
  output logic                so_d,
  output logic                so_drive_low
);
  ssc_word_t shreg_w;
  ssc_word_t sw_w;
  logic      accept_w;

  ssc_shift_stage u_shift (
    .sclk   (sclk),
    .rst_n  (rst_n),
    .sync_n (sync_n),
    .sdi    (sdi),
    .shreg_q(shreg_w),
    .accept (accept_w)
  );

  ssc_chain_stage u_chain (
    .sclk        (sclk),
    .rst_n       (rst_n),
    .shreg       (shreg_w),
    .so_d        (so_d),
    .so_drive_low(so_drive_low)
  );

  ssc_latch_stage u_latch (
    .sync_n(sync_n),
    .rst_n (rst_n),
    .shreg (shreg_w),
    .sw_q  (sw_w)
  );

  assign sw_en = sw_w;
endmodule

// File: rtl/ssc_chk.sv
`timescale 1ns/1ps
module ssc_chk
  import ssc_pkg::*;
(
  input logic      sclk,
  input logic      rst_n,
  input logic      sync_n,
  input logic      sdi,
  input logic      accept,
  input ssc_word_t shreg,
  input ssc_word_t sw_en,
  input logic      so_d,
  input logic      so_drive_low
);
  always @(negedge sclk) begin
    if (!rst_n) begin
      p_reset_clear_r1: assert (sw_en == '0 && shreg == '0 && so_d == 1'b0 && so_drive_low == 1'b1)
        else $error("reset state not clear");
    end
  end

  p_shift_lsb_r2: assert property (@(negedge sclk) disable iff (!rst_n)
    accept |=> shreg[0] == $past(sdi));

  p_shift_up_r2: assert property (@(negedge sclk) disable iff (!rst_n)
    accept |=> shreg[MSB_IDX:1] == $past(shreg[MSB_IDX-1:0]));

  p_idle_hold_r3: assert property (@(negedge sclk) disable iff (!rst_n)
    sync_n |=> $stable(shreg));

  p_latch_word_r4: assert property (@(negedge sclk) disable iff (!rst_n)
    $rose(sync_n) |-> sw_en == to_enables(shreg));

  p_sw_quiet_r5: assert property (@(negedge sclk) disable iff (!rst_n)
    !sync_n |-> $stable(sw_en));

  p_chain_msb_r6: assert property (@(negedge sclk) disable iff (!rst_n)
    so_d == shreg[MSB_IDX] && so_drive_low == !so_d);
endmodule

bind serial_switch_ctl ssc_chk chk_i (
  .sclk        (sclk),
  .rst_n       (rst_n),
  .sync_n      (sync_n),
  .sdi         (sdi),
  .accept      (accept_w),
  .shreg       (shreg_w),
  .sw_en       (sw_en),
  .so_d        (so_d),
  .so_drive_low(so_drive_low)
);

// File: tb/serial_switch_ctl_tb_top.sv
`timescale 1ns/1ps
module serial_switch_ctl_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz, used directly as the serial clock

  logic       sdi = 1'b0;
  logic       sync_n = 1'b1;
  logic       rst_n = 1'b0;
  logic [7:0] sw_a, sw_b;
  logic       so_a, so_b, dl_a, dl_b;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  serial_switch_ctl dut_i (
    .sclk(clk), .sdi(sdi), .sync_n(sync_n), .rst_n(rst_n),
    .sw_en(sw_a), .so_d(so_a), .so_drive_low(dl_a)
  );

  // Downstream unit chained on the first unit's serial output (R8).
  serial_switch_ctl dut_b (
    .sclk(clk), .sdi(so_a), .sync_n(sync_n), .rst_n(rst_n),
    .sw_en(sw_b), .so_d(so_b), .so_drive_low(dl_b)
  );

  typedef struct packed {
    logic [4:0]  nb;
    logic [15:0] bits;
    logic [7:0]  exp;
  } vec_t;

  // Walked in order; the 4-bit and 12-bit frames depend on earlier contents (R7).
  localparam vec_t VECS [7] = '{
    '{5'd8,  16'h00A5, 8'hA5},
    '{5'd8,  16'h003C, 8'h3C},
    '{5'd8,  16'h00FF, 8'hFF},
    '{5'd8,  16'h0000, 8'h00},
    '{5'd8,  16'h0081, 8'h81},
    '{5'd4,  16'h000B, 8'h1B},
    '{5'd12, 16'h0C5A, 8'h5A}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drives one frame, MSB first; inputs change 1 ns after a rising edge.
  task automatic send(input int nb, input logic [15:0] bits, input logic [7:0] hold);
    @(posedge clk); #1;
    sync_n = 1'b0;
    for (int i = nb - 1; i >= 0; i--) begin
      sdi = bits[i];
      if (i == nb / 2) chk("R5 enables steady mid-frame", {8'h0, sw_a}, {8'h0, hold});
      @(posedge clk); #1;
    end
    sync_n = 1'b1;
    #0.5;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog all-requirements actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] prev;

    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    chk("R1 enables cleared", {8'h0, sw_a}, 16'h0000);
    chk("R1 chain out low", {15'h0, so_a}, 16'h0000);
    chk("R1 pull-down active", {15'h0, dl_a}, 16'h0001);
    rst_n = 1'b1;

    // R2/R4/R6/R7: table of frames
    prev = 8'h00;
    for (int v = 0; v < 7; v++) begin
      send(VECS[v].nb, VECS[v].bits, prev);
      chk("R4 R2 R7 latched word", {8'h0, sw_a}, {8'h0, VECS[v].exp});
      chk("R6 chain out is msb", {15'h0, so_a}, {15'h0, VECS[v].exp[7]});
      chk("R6 open-drain drive", {15'h0, dl_a}, {15'h0, ~VECS[v].exp[7]});
      prev = VECS[v].exp;
    end

    // R6: read back 5A bit by bit through the chain output
    @(posedge clk); #1;
    sync_n = 1'b0;
    for (int k = 0; k < 8; k++) begin
      chk("R6 readback bit", {15'h0, so_a}, {15'h0, prev[7-k]});
      sdi = 1'b0;
      @(posedge clk); #1;
    end
    sync_n = 1'b1;
    #0.5;
    chk("R4 zeros latched after readback", {8'h0, sw_a}, 16'h0000);

    // R3: clocks with the strobe high are ignored
    send(8, 16'h005A, 8'h00);
    chk("R4 reload", {8'h0, sw_a}, 16'h005A);
    sdi = 1'b1;
    repeat (6) @(posedge clk);
    #1;
    chk("R3 chain out unchanged", {15'h0, so_a}, 16'h0000);
    sync_n = 1'b0;
    #0.5;
    sync_n = 1'b1;
    #0.25;
    chk("R3 register unchanged by idle clocks", {8'h0, sw_a}, 16'h005A);

    // R8: two chained units loaded with one 16-bit frame
    send(16, 16'h96E1, 8'h5A);
    chk("R8 near unit gets last byte", {8'h0, sw_a}, 16'h00E1);
    chk("R8 far unit gets first byte", {8'h0, sw_b}, 16'h0096);

    // R9: reset in the middle of a frame
    @(posedge clk); #1;
    sync_n = 1'b0;
    for (int i = 0; i < 4; i++) begin
      sdi = 1'b1;
      @(posedge clk); #1;
    end
    rst_n = 1'b0;
    #0.5;
    chk("R9 R1 enables cleared at once", {8'h0, sw_a}, 16'h0000);
    chk("R9 far unit cleared", {8'h0, sw_b}, 16'h0000);
    chk("R9 R6 pull-down after reset", {15'h0, dl_a}, 16'h0001);
    sdi = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(posedge clk); #1;
    sync_n = 1'b1;
    #0.5;
    chk("R9 partial word discarded", {8'h0, sw_a}, 16'h0000);
    send(8, 16'h003C, 8'h00);
    chk("R9 next frame loads", {8'h0, sw_a}, 16'h003C);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule